// File: doc/BRIEF.md
# Multi-digit lookahead BCD up/down counter

This block is a decimal counter of N binary-coded-decimal digits. All digit registers share one clock, so a carry or borrow that crosses several digits lands on one rising edge. Every digit's advance enable is formed in parallel from a global active-low enable and the terminal-count flags of all digits below it. The global enable is therefore part of every digit's gate, not only the lowest one.

A single direction input selects counting up or down. The same input also selects which value counts as terminal for every digit: 9 when counting up and 0 when counting down. An active-low parallel load presets all digits from a BCD word. It acts at once and takes priority over counting. A carry flag reports that the whole counter sits at its terminal value while counting is enabled, so the next edge wraps it.

Top module: `bcd_lookahead_counter`

## Requirements
- R1: While rst_ni is low, every digit register is cleared at once, without waiting for a clock, and value_o reads all zeros.
- R2: When a digit advances with up_i high, codes 0 to 8 step to the next value, and code 9 or any code from 10 to 15 becomes 0.
- R3: When a digit advances with up_i low, code 0 becomes 9 and any other code (1 to 15) steps down by one.
- R4: While cnt_en_ni is high and load_ni is high, no clock edge changes value_o.
- R5: On an edge where cnt_en_ni is low and load_ni is high, digit k advances only if all digits below it are at terminal count (9 up, 0 down). With valid BCD contents, value_o therefore moves by exactly one decimal step modulo 10^N.
- R6: carry_o is high exactly when cnt_en_ni is low, load_ni is high, and every digit is at terminal count for the present up_i.
- R7: While load_ni is low, value_o shows preset_i directly and counting is suppressed. The registers take preset_i on the falling edge of load_ni and on every rising clock edge while it stays low, so counting resumes from the last value taken.
- R8: With cnt_en_ni low, an edge from all 9s counting up gives all 0s, and an edge from all 0s counting down gives all 9s.
- R9: A change of up_i alone changes the terminal-count decision, and so carry_o, without a clock edge.
- R10: Digit k occupies bits 4k+3 down to 4k of preset_i and value_o. Digit 0 is the least significant decimal digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock for all digit registers, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_ni | input | 1 | Global count enable, active low |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| load_ni | input | 1 | Parallel load, active low, asynchronous |
| preset_i | input | 4*N | BCD preset word, digit 0 in the low nibble |
| value_o | output | 4*N | BCD count value |
| carry_o | output | 1 | Carry (up) or borrow (down) from the top digit |

## Verification
The bench builds the counter with its default N = 4, so the full range of 10 000 states is short enough to walk. A complete up sweep from 0000 through the 9999-to-0000 wrap compares every state against a decimal reference integer. Table vectors cover multi-digit borrows, disabled counting and the downward 0000-to-9999 wrap. Directed cases load the non-decimal codes 10 to 15, hold load low across clock edges, and flip the direction input with no clock edge.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

  typedef logic [3:0] bcd_t;

  localparam bcd_t BCD_TOP = 4'd9;

  // next code for one advancing digit; non-decimal codes fold as specified
  function automatic bcd_t bcd_next(bcd_t cur, logic up);
    bcd_t nxt;
    if (up) nxt = (cur >= BCD_TOP) ? 4'd0 : cur + 4'd1;
    else    nxt = (cur == 4'd0) ? BCD_TOP : cur - 4'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/bcd_digit.sv
module bcd_digit
  import bcd_cnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_ni,
  input  bcd_t preset_i,
  input  logic up_i,
  input  logic step_i,
  output bcd_t q_o,
  output logic tc_o
);

  bcd_t q;

  always_ff @(posedge clk_i or negedge rst_ni or negedge load_ni) begin
    if (!rst_ni)       q <= '0;
    else if (!load_ni) q <= preset_i;
    else if (step_i)   q <= bcd_next(q, up_i);
  end

  assign q_o  = q;
  assign tc_o = up_i ? (q == BCD_TOP) : (q == 4'd0);

  p_up_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(load_ni) && load_ni && $past(step_i) && $past(up_i)
     && ($past(q) < BCD_TOP)) |-> (q == $past(q) + 4'd1));

  p_down_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(load_ni) && load_ni && $past(step_i) && !$past(up_i)
     && ($past(q) == 4'd0)) |-> (q == BCD_TOP));

  p_digit_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(load_ni) && load_ni && !$past(step_i)) |-> $stable(q));

endmodule

// File: rtl/bcd_lookahead.sv
module bcd_lookahead #(
  parameter int N = 4
) (
  input  logic         en_i,
  input  logic [N-1:0] tc_i,
  output logic [N-1:0] step_o,
  output logic         carry_o
);

  // each stage sees a flat AND of the global enable and all lower tc flags
  for (genvar k = 0; k < N; k++) begin : g_gate
    if (k == 0) begin : g_base
      assign step_o[k] = en_i;
    end else begin : g_upper
      assign step_o[k] = en_i & (&tc_i[k-1:0]);
    end
  end

  assign carry_o = en_i & (&tc_i);

endmodule

// File: rtl/bcd_lookahead_counter.sv
module bcd_lookahead_counter
  import bcd_cnt_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_ni,
  input  logic         up_i,
  input  logic         load_ni,
  input  logic [4*N-1:0] preset_i,
  output logic [4*N-1:0] value_o,
  output logic         carry_o
);

  localparam int W = 4 * N;
  localparam logic [W-1:0] ALL_NINES = {N{BCD_TOP}};

  logic [W-1:0] state;
  logic [N-1:0] tc;
  logic [N-1:0] step;
  logic         en;

  assign en = ~cnt_en_ni & load_ni;

  for (genvar k = 0; k < N; k++) begin : g_digit
    bcd_digit u_digit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_ni  (load_ni),
      .preset_i (preset_i[4*k +: 4]),
      .up_i     (up_i),
      .step_i   (step[k]),
      .q_o      (state[4*k +: 4]),
      .tc_o     (tc[k])
    );
  end

  bcd_lookahead #(.N(N)) u_chain (
    .en_i    (en),
    .tc_i    (tc),
    .step_o  (step),
    .carry_o (carry_o)
  );

  // preset is visible immediately while load is held
  assign value_o = load_ni ? state : preset_i;

  p_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(cnt_en_ni) && $past(load_ni) && load_ni) |-> $stable(value_o));

  p_wrap_up_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(carry_o) && $past(up_i) && load_ni) |-> (value_o == '0));

  p_wrap_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(carry_o) && !$past(up_i) && load_ni) |-> (value_o == ALL_NINES));

  p_carry_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |-> !carry_o);

endmodule

// File: tb/bcd_lookahead_counter_test.sv
`timescale 1ns/1ps
module bcd_lookahead_counter_test;

  localparam int N   = 4;
  localparam int W   = 4 * N;
  localparam int MOD = 10000;

  typedef struct packed {
    logic [W-1:0] preset;
    logic         up;
    logic         en;
    logic [7:0]   steps;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'h0000, 1'b1, 1'b1, 8'd12},
    '{16'h9995, 1'b1, 1'b1, 8'd8},
    '{16'h0003, 1'b0, 1'b1, 8'd6},
    '{16'h1000, 1'b0, 1'b1, 8'd3},
    '{16'h4567, 1'b1, 1'b0, 8'd5},
    '{16'h0909, 1'b1, 1'b1, 8'd3},
    '{16'h0990, 1'b0, 1'b1, 8'd2},
    '{16'h2468, 1'b0, 1'b0, 8'd4}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cnt_en_ni = 1'b1;
  logic up_i = 1'b1;
  logic load_ni = 1'b1;
  logic [W-1:0] preset_i = '0;
  logic [W-1:0] value_o;
  logic carry_o;

  int n_chk = 0;
  int n_bad = 0;
  int ref_val = 0;

  always #2.5 clk_i = ~clk_i;

  bcd_lookahead_counter #(.N(N)) uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_en_ni (cnt_en_ni),
    .up_i      (up_i),
    .load_ni   (load_ni),
    .preset_i  (preset_i),
    .value_o   (value_o),
    .carry_o   (carry_o)
  );

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] b = '0;
    int t = v;
    for (int k = 0; k < N; k++) begin
      b[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return b;
  endfunction

  function automatic int from_bcd(logic [W-1:0] b);
    int v = 0;
    for (int k = N - 1; k >= 0; k--) v = v * 10 + int'(b[4*k +: 4]);
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // R7: preset shows at once, registers take it while load is low
  task automatic do_load(logic [W-1:0] p);
    @(negedge clk_i);
    cnt_en_ni = 1'b1;
    preset_i  = p;
    load_ni   = 1'b0;
    #1 check(value_o == p, "R7", value_o, p);
    @(negedge clk_i);
    load_ni = 1'b1;
    #1 check(value_o == p, "R7", value_o, p);
    ref_val = from_bcd(p);
  endtask

  task automatic do_step(logic up, logic en, string tag);
    logic exp_c;
    @(negedge clk_i);
    up_i      = up;
    cnt_en_ni = ~en;
    #1;
    exp_c = en && (up ? (ref_val == MOD - 1) : (ref_val == 0));
    check(carry_o == exp_c, "R6", W'(carry_o), W'(exp_c));
    if (en) ref_val = up ? (ref_val + 1) % MOD : (ref_val + MOD - 1) % MOD;
    @(posedge clk_i);
    #1 check(value_o == to_bcd(ref_val), tag, value_o, to_bcd(ref_val));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk_i);
    #1 check(value_o == '0, "R1", value_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // table of vectors
    for (int i = 0; i < $size(VECS); i++) begin
      do_load(VECS[i].preset);
      for (int s = 0; s < int'(VECS[i].steps); s++)
        do_step(VECS[i].up, VECS[i].en, VECS[i].en ? "R5" : "R4");
    end

    // R10: digit 0 is the low nibble
    do_load(16'h0019);
    do_step(1'b1, 1'b1, "R10");
    check(value_o == 16'h0020, "R10", value_o, 16'h0020);

    // R8: full up sweep through the all-9s wrap
    do_load(16'h0000);
    for (int i = 0; i < MOD + 2; i++) do_step(1'b1, 1'b1, (ref_val == MOD - 1) ? "R8" : "R5");
    // R8: all-0s wrap downward
    do_load(16'h0000);
    do_step(1'b0, 1'b1, "R8");
    check(value_o == 16'h9999, "R8", value_o, 16'h9999);

    // R2: non-decimal code going up folds to 0 without carry
    do_load(16'h000C);
    @(negedge clk_i); up_i = 1'b1; cnt_en_ni = 1'b0;
    @(posedge clk_i);
    #1 check(value_o == 16'h0000, "R2", value_o, 16'h0000);
    @(negedge clk_i); cnt_en_ni = 1'b1;
    // R3: non-decimal code going down steps by one
    do_load(16'h000C);
    @(negedge clk_i); up_i = 1'b0; cnt_en_ni = 1'b0;
    @(posedge clk_i);
    #1 check(value_o == 16'h000B, "R3", value_o, 16'h000B);
    @(negedge clk_i); cnt_en_ni = 1'b1;

    // R9: direction alone flips the carry decision
    do_load(16'h9999);
    @(negedge clk_i); up_i = 1'b1; cnt_en_ni = 1'b0;
    #1 check(carry_o == 1'b1, "R9", W'(carry_o), W'(1));
    up_i = 1'b0;
    #1 check(carry_o == 1'b0, "R9", W'(carry_o), W'(0));
    cnt_en_ni = 1'b1;
    #1 check(carry_o == 1'b0, "R6", W'(carry_o), W'(0));

    // R7: load held across edges while enabled
    @(negedge clk_i);
    up_i = 1'b1; cnt_en_ni = 1'b0; preset_i = 16'h1234; load_ni = 1'b0;
    @(posedge clk_i);
    #1 check(value_o == 16'h1234, "R7", value_o, 16'h1234);
    check(carry_o == 1'b0, "R6", W'(carry_o), W'(0));
    preset_i = 16'h5678;
    #1 check(value_o == 16'h5678, "R7", value_o, 16'h5678);
    @(posedge clk_i);
    @(negedge clk_i);
    cnt_en_ni = 1'b1; load_ni = 1'b1;
    #1 check(value_o == 16'h5678, "R7", value_o, 16'h5678);
    ref_val = 5678;
    do_step(1'b1, 1'b1, "R7");

    // R1: asynchronous reset mid-run
    @(negedge clk_i); cnt_en_ni = 1'b0;
    #1 rst_ni = 1'b0;
    #0.5 check(value_o == '0, "R1", value_o, '0);
    @(negedge clk_i); cnt_en_ni = 1'b1;
    @(negedge clk_i); rst_ni = 1'b1;
    #1 check(value_o == '0, "R1", value_o, '0);

    report();
    $finish;
  end

endmodule